// File: doc/BRIEF.md
# Buffered Fat-Tree Switch Node

This block is one packet-switched node of a directional fat tree. It has three ports: a left child, a right child and a parent. Each port has an input and an output. A packet is one 32-bit data word plus a destination leaf address. Every input steers its packet to one of the two outputs it can reach. Every output merges two such streams through a pair of 16-entry FIFOs and a round-robin arbiter.

A packet coming down from the parent is steered by a single address bit. The parameter `LVL` chooses which bit, so each tree level resolves one bit of the address. A packet coming up from a child stays inside this node's subtree only when its address bits above `LVL` match the node's own base address. In that case it turns to the sibling child; otherwise it continues to the parent.

Every transfer uses a valid/ready handshake. An input's ready reflects whether the FIFO its packet is heading for still has room. A full FIFO therefore holds the sender until the output drains.

Top module: `tsw_node`

## Requirements
- R1: While `rst_n` is low at a clock edge, every FIFO empties. After reset, all `out_valid` bits are 0, and every `in_ready` bit is 1.
- R2: Port index 0 is the left child, 1 is the right child and 2 is the parent. A packet accepted on the parent input leaves on output 0 when bit `LVL` (default 1) of its destination is 0, and on output 1 when that bit is 1.
- R3: A packet accepted on a child input leaves on the parent output (index 2) when its destination bits above `LVL` differ from those of `NODE_BASE` (default 4'b0100).
- R4: A packet accepted on a child input whose destination bits above `LVL` equal those of `NODE_BASE` leaves on the other child's output.
- R5: Destination and data leave unchanged. Packets taking the same input-to-output path leave in the order they arrived.
- R6: An output with `out_valid` high and `out_ready` low keeps `out_valid`, `out_dest` and `out_data` unchanged on the next cycle.
- R7: Each merge input holds 16 packets. An input's `in_ready` is low exactly when the FIFO its current destination selects is full. A packet moves only when valid and ready are both high.
- R8: When both FIFOs feeding an output hold packets, the output serves them alternately after each transfer.
- R9: A packet accepted at a clock edge into an empty path shows on its output right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 3 | Packet offered on each input (0 left, 1 right, 2 parent) |
| in_dest | input | 3 x ADDR_W | Destination leaf address per input |
| in_data | input | 3 x DATA_W | Payload per input |
| in_ready | output | 3 | Input may transfer this cycle |
| out_valid | output | 3 | Packet offered on each output |
| out_dest | output | 3 x ADDR_W | Destination of the offered packet |
| out_data | output | 3 x DATA_W | Payload of the offered packet |
| out_ready | input | 3 | Downstream accepts the offered packet |

## Verification
The bench drives one output stalled with a single input held valid. It expects exactly sixteen acceptances and then a low ready. A design that sized or compared its FIFO count wrongly would drop a packet or accept a seventeenth. Two children both send to the parent while it is stalled, and the bench then releases it. An arbiter that was not round-robin would drain one child first. The bench also sends destinations that sit just inside and just outside the subtree, and on both sides of the steering bit. A wrong subtree compare sends a packet up instead of across, and a wrong level index sends it to the wrong child. Random traffic with random output stalls is run against a queue model, which catches a grant that changes while an output is stalled and any loss or reordering of packets.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
// Shared constants for the fat-tree switch node.
// Assumes three ports in a fixed index order used by every module.
package tsw_pkg;
    localparam int PORTS   = 3;
    localparam int P_LEFT  = 0;
    localparam int P_RIGHT = 1;
    localparam int P_UP    = 2;
endpackage

// File: rtl/tsw_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with a ready-when-not-full write side and a
// show-ahead read side. Assumes the reader pops only when data is present.
module tsw_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    input  logic [W-1:0] push_data,
    output logic         push_ready,
    output logic         pop_valid,
    output logic [W-1:0] pop_data,
    input  logic         pop_en
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign push_ready = (count != CW'(DEPTH));
    assign pop_valid  = (count != '0);
    assign pop_data   = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop_en && pop_valid;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_blocked_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> (count <= $past(count)));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> pop_valid);
endmodule

// File: rtl/tsw_split.sv
`timescale 1ns/1ps
// Steering unit for one input. The parent variant picks a child by one
// address bit; the child variant picks sibling (0) or parent (1) by
// comparing the address bits above the level with the node base.
module tsw_split #(
    parameter int                ADDR_W      = 4,
    parameter int                LVL         = 1,
    parameter logic [ADDR_W-1:0] NODE_BASE   = 4'b0100,
    parameter bit                FROM_PARENT = 1'b0
) (
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_dest,
    output logic              in_ready,
    output logic [1:0]        out_valid,
    input  logic [1:0]        out_ready
);
    logic sel;
    logic unused_dest;

    assign unused_dest = ^in_dest;

    generate
        if (FROM_PARENT) begin : g_down
            assign sel = in_dest[LVL];
        end else begin : g_up
            assign sel = (in_dest >> (LVL + 1)) != (NODE_BASE >> (LVL + 1));
        end
    endgenerate

    // Offer the packet to the selected side only; ready comes from that side.
    always_comb begin
        out_valid = {in_valid && sel, in_valid && !sel};
        in_ready  = out_ready[sel];
    end
endmodule

// File: rtl/tsw_merge.sv
`timescale 1ns/1ps
// Output unit: two input FIFOs and a round-robin arbiter. The grant is
// frozen while the output is stalled so the offered packet stays put.
module tsw_merge #(
    parameter int W     = 36,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        in_valid,
    input  logic [1:0][W-1:0] in_data,
    output logic [1:0]        in_ready,
    output logic              out_valid,
    output logic [W-1:0]      out_data,
    input  logic              out_ready
);
    logic [1:0]        f_v;
    logic [1:0][W-1:0] f_d;
    logic [1:0]        f_pop;
    logic              gnt, prio_q, lock_q, gnt_q, take;

    generate
        for (genvar j = 0; j < 2; j++) begin : g_in
            tsw_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
                .clk        (clk),
                .rst_n      (rst_n),
                .push_valid (in_valid[j]),
                .push_data  (in_data[j]),
                .push_ready (in_ready[j]),
                .pop_valid  (f_v[j]),
                .pop_data   (f_d[j]),
                .pop_en     (f_pop[j])
            );
            assign f_pop[j] = take && (gnt == 1'(j));
        end
    endgenerate

    // Pick a source: held grant when stalled, else priority on a tie.
    always_comb begin
        if (lock_q)          gnt = gnt_q;
        else if (&f_v)       gnt = prio_q;
        else                 gnt = f_v[1];
        out_valid = |f_v;
        out_data  = f_d[gnt];
        take      = out_valid && out_ready;
    end

    // Arbiter state: rotate priority on each transfer, remember stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= 1'b0;
            lock_q <= 1'b0;
            gnt_q  <= 1'b0;
        end else begin
            if (take) prio_q <= ~gnt;
            lock_q <= out_valid && !out_ready;
            gnt_q  <= gnt;
        end
    end

    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((&f_v) -> (gnt != $past(gnt))));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && out_data == $past(out_data)));
endmodule

// File: rtl/tsw_node.sv
`timescale 1ns/1ps
// Three-port fat-tree switch node. Each port pairs an input steering unit
// with an output merge unit. Assumes well-formed tree addressing: a packet
// from a child never targets that same child.
module tsw_node #(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 4,
    parameter int                LVL       = 1,
    parameter logic [ADDR_W-1:0] NODE_BASE = 4'b0100,
    parameter int                DEPTH     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             in_valid,
    input  logic [2:0][ADDR_W-1:0] in_dest,
    input  logic [2:0][DATA_W-1:0] in_data,
    output logic [2:0]             in_ready,
    output logic [2:0]             out_valid,
    output logic [2:0][ADDR_W-1:0] out_dest,
    output logic [2:0][DATA_W-1:0] out_data,
    input  logic [2:0]             out_ready
);
    import tsw_pkg::*;
    localparam int PKT_W = ADDR_W + DATA_W;

    logic [PORTS-1:0][PKT_W-1:0] pk;
    logic [1:0]                  sp_v [PORTS];
    logic [1:0]                  sp_r [PORTS];
    logic [1:0]                  mg_v [PORTS];
    logic [1:0]                  mg_r [PORTS];
    logic [1:0][PKT_W-1:0]       mg_d [PORTS];
    logic [PKT_W-1:0]            mo_d [PORTS];

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            assign pk[p] = {in_dest[p], in_data[p]};

            tsw_split #(
                .ADDR_W(ADDR_W), .LVL(LVL), .NODE_BASE(NODE_BASE),
                .FROM_PARENT(p == P_UP)
            ) u_split (
                .in_valid  (in_valid[p]),
                .in_dest   (in_dest[p]),
                .in_ready  (in_ready[p]),
                .out_valid (sp_v[p]),
                .out_ready (sp_r[p])
            );

            tsw_merge #(.W(PKT_W), .DEPTH(DEPTH)) u_merge (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (mg_v[p]),
                .in_data   (mg_d[p]),
                .in_ready  (mg_r[p]),
                .out_valid (out_valid[p]),
                .out_data  (mo_d[p]),
                .out_ready (out_ready[p])
            );

            assign {out_dest[p], out_data[p]} = mo_d[p];
        end
    endgenerate

    // Left output: slot 0 from parent, slot 1 from right child.
    assign mg_v[P_LEFT]  = {sp_v[P_RIGHT][0], sp_v[P_UP][0]};
    assign mg_d[P_LEFT]  = {pk[P_RIGHT], pk[P_UP]};
    // Right output: slot 0 from parent, slot 1 from left child.
    assign mg_v[P_RIGHT] = {sp_v[P_LEFT][0], sp_v[P_UP][1]};
    assign mg_d[P_RIGHT] = {pk[P_LEFT], pk[P_UP]};
    // Parent output: slot 0 from left child, slot 1 from right child.
    assign mg_v[P_UP]    = {sp_v[P_RIGHT][1], sp_v[P_LEFT][1]};
    assign mg_d[P_UP]    = {pk[P_RIGHT], pk[P_LEFT]};

    // Backpressure from each FIFO to the steering unit feeding it.
    assign sp_r[P_UP]    = {mg_r[P_RIGHT][0], mg_r[P_LEFT][0]};
    assign sp_r[P_LEFT]  = {mg_r[P_UP][0], mg_r[P_RIGHT][1]};
    assign sp_r[P_RIGHT] = {mg_r[P_UP][1], mg_r[P_LEFT][1]};

    // Independent subtree test used only by the port-level checks below.
    logic [1:0] chk_inside;
    assign chk_inside[0] = (in_dest[0] >> (LVL + 1)) == (NODE_BASE >> (LVL + 1));
    assign chk_inside[1] = (in_dest[1] >> (LVL + 1)) == (NODE_BASE >> (LVL + 1));

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == 3'b000));
    p_down_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[2] && in_ready[2] && !in_dest[2][LVL]) |=> out_valid[0]);
    p_down_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[2] && in_ready[2] && in_dest[2][LVL]) |=> out_valid[1]);
    p_up_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && in_ready[0] && !chk_inside[0]) |=> out_valid[2]);
    p_up_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[1] && in_ready[1] && !chk_inside[1]) |=> out_valid[2]);
    p_across_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && in_ready[0] && chk_inside[0]) |=> out_valid[1]);
    p_across_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[1] && in_ready[1] && chk_inside[1]) |=> out_valid[0]);
endmodule

// File: tb/tsw_node_bench.sv
`timescale 1ns/1ps
module tsw_node_bench;
    localparam int         DW = 32;
    localparam int         AW = 4;
    localparam int         LVL = 1;
    localparam logic [3:0] BASE = 4'b0100;
    localparam int         DEPTH = 16;
    typedef logic [AW+DW-1:0] pkt_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]         in_valid = '0;
    logic [2:0][AW-1:0] in_dest = '0;
    logic [2:0][DW-1:0] in_data = '0;
    logic [2:0]         in_ready;
    logic [2:0]         out_valid;
    logic [2:0][AW-1:0] out_dest;
    logic [2:0][DW-1:0] out_data;
    logic [2:0]         out_ready = 3'b111;

    always #2.5 clk = ~clk;

    tsw_node u_tsw_node (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_dest(out_dest), .out_data(out_data), .out_ready(out_ready)
    );

    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    pkt_t mq [6][$];
    bit   prio [3];
    bit   lockm [3];
    bit   lastg [3];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Queue index = output*2 + slot, derived from the routing requirements.
    function automatic int qidx(input int p, input logic [3:0] d);
        if (p == 2) return d[LVL] ? 2 : 0;
        if ((d >> (LVL + 1)) == (BASE >> (LVL + 1))) return (1 - p) * 2 + 1;
        return 4 + p;
    endfunction

    // One clock: compare against the model, then advance the model.
    task automatic step();
        logic [2:0] er, ev;
        bit         eg [3];
        #1;
        for (int p = 0; p < 3; p++) er[p] = mq[qidx(p, in_dest[p])].size() < DEPTH;
        for (int m = 0; m < 3; m++) begin
            bit v0, v1;
            v0 = mq[m*2].size() > 0;
            v1 = mq[m*2+1].size() > 0;
            ev[m] = v0 | v1;
            eg[m] = lockm[m] ? lastg[m] : ((v0 && v1) ? prio[m] : v1);
        end
        chk(in_ready == er, "R7", "in_ready", 64'(in_ready), 64'(er));
        chk(out_valid == ev, "R9", "out_valid", 64'(out_valid), 64'(ev));
        for (int m = 0; m < 3; m++)
            if (ev[m])
                chk({out_dest[m], out_data[m]} == mq[m*2+int'(eg[m])][0], "R5", "packet",
                    64'({out_dest[m], out_data[m]}), 64'(mq[m*2+int'(eg[m])][0]));
        @(posedge clk);
        for (int m = 0; m < 3; m++) begin
            if (ev[m] && out_ready[m]) begin
                void'(mq[m*2+int'(eg[m])].pop_front());
                prio[m] = ~eg[m];
            end
            lockm[m] = ev[m] && !out_ready[m];
            lastg[m] = eg[m];
        end
        for (int p = 0; p < 3; p++)
            if (in_valid[p] && er[p]) mq[qidx(p, in_dest[p])].push_back({in_dest[p], in_data[p]});
        @(negedge clk);
    endtask

    // Send one packet on port p, then check which output shows it.
    task automatic route_one(input int p, input logic [3:0] d, input logic [31:0] v,
                             input logic [2:0] exp_ov, input int exp_o, input string req);
        in_valid[p] = 1'b1; in_dest[p] = d; in_data[p] = v;
        step();
        in_valid = '0;
        #0.5;
        chk(out_valid == exp_ov && out_data[exp_o] == v && out_dest[exp_o] == d, req,
            "route", {28'(out_valid), out_data[exp_o]}, {28'(exp_ov), v});
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int acc;
        int seq [$];
        bit alt;
        for (int m = 0; m < 3; m++) begin prio[m] = 0; lockm[m] = 0; lastg[m] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: empty after reset
        chk(out_valid == 3'b000, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
        chk(in_ready == 3'b111, "R1", "in_ready after reset", 64'(in_ready), 64'h7);
        @(negedge clk);

        // R2: steering bit from the parent
        route_one(2, 4'b0100, 32'h1111_0001, 3'b001, 0, "R2");
        route_one(2, 4'b0110, 32'h1111_0002, 3'b010, 1, "R2");
        // R3: outside the subtree goes up
        route_one(0, 4'b1000, 32'h2222_0001, 3'b100, 2, "R3");
        route_one(1, 4'b0001, 32'h2222_0002, 3'b100, 2, "R3");
        // R4: inside the subtree turns across
        route_one(0, 4'b0111, 32'h3333_0001, 3'b010, 1, "R4");
        route_one(1, 4'b0100, 32'h3333_0002, 3'b001, 0, "R4");

        // R7: stalled left output accepts exactly sixteen from the parent
        out_ready[0] = 1'b0;
        acc = 0;
        for (int i = 0; i < 20; i++) begin
            in_valid[2] = 1'b1; in_dest[2] = 4'b0101; in_data[2] = 32'hA000_0000 + i;
            #0.5;
            if (in_ready[2]) acc++;
            step();
        end
        #0.5;
        chk(acc == 16, "R7", "accepted while stalled", 64'(acc), 64'd16);
        chk(in_ready[2] == 1'b0, "R7", "ready when full", 64'(in_ready[2]), 64'd0);
        in_valid = '0;
        // R6: stalled head stays put
        alt = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            #0.5;
            if (!(out_valid[0] && out_data[0] == 32'hA000_0000)) alt = 1'b0;
        end
        chk(alt, "R6", "stalled output stable", 64'(out_data[0]), 64'hA000_0000);
        out_ready[0] = 1'b1;
        repeat (20) step();

        // R8: both children queue for the stalled parent output, then drain
        out_ready[2] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_valid[0] = 1'b1; in_dest[0] = 4'b1001; in_data[0] = 32'h100 + i;
            in_valid[1] = 1'b1; in_dest[1] = 4'b0010; in_data[1] = 32'h200 + i;
            step();
        end
        in_valid = '0;
        out_ready[2] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #0.5;
            if (out_valid[2]) seq.push_back(int'(out_data[2][9:8]));
            step();
        end
        alt = (seq.size() == 6);
        for (int i = 1; i < seq.size(); i++) if (seq[i] == seq[i-1]) alt = 1'b0;
        chk(alt, "R8", "alternating service", 64'(seq.size()), 64'd6);

        // R5/R7/R9: random traffic and stalls against the queue model
        for (int i = 0; i < 3000; i++) begin
            in_valid  = 3'($urandom);
            in_dest   = {4'($urandom), 4'($urandom), 4'($urandom)};
            in_data   = {32'($urandom), 32'($urandom), 32'($urandom)};
            out_ready = 3'($urandom) | 3'($urandom);
            step();
        end
        in_valid = '0;
        out_ready = 3'b111;
        repeat (40) step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule